// File: doc/BRIEF.md
# Dual Down-Counting Timer Peripheral

This block holds two independent timer channels behind a 32-bit register port. Each channel divides the input clock by a programmable prescale value plus one. On every prescaled tick it decrements a 24-bit counter that starts from a programmed initial value. When the counter reaches zero the channel sets its bit in a shared status register. It then either reloads and keeps running (periodic mode) or stops with its enable cleared (one-shot mode).

Software arms a channel in two steps. It first writes the initial count, then writes the control word with the enable bit set. Clearing the enable bit stops the channel while its mode is kept. Status bits stay set until software writes a one to them. Each channel drives an interrupt line while its status bit and its interrupt-enable bit are both set.

Register reads are combinational from the address. A write takes effect at the clock edge that samples it.

Top module: `dual_timer`

## Requirements
- R1: Byte offsets are 0x00 control of channel 0, 0x04 control of channel 1, 0x08 initial count of channel 0, 0x0C initial count of channel 1, 0x14 live count of channel 1 and 0x18 status. Initial-count registers read back bits [23:0] as written, with zero above them. Any other offset reads zero.
- R2: The control word has the enable bit at bit 30, the interrupt enable at bit 29 and the mode select at bit 27 (1 = periodic, 0 = one-shot). The prescale value sits in bits [7:0]. All other control bits read as zero.
- R3: While enabled, the counter changes once every (prescale + 1) clock cycles, and never by more than one step.
- R4: A control write that takes the enable bit from 0 to 1 loads the counter from the initial count and restarts the prescaler. Offset 0x14 returns channel 1's counter, zero-extended.
- R5: In periodic mode, the tick that brings the counter to zero sets the status bit and leaves the channel enabled. The next tick loads the initial count. An initial count of zero therefore sets the status bit on every tick.
- R6: In one-shot mode, the tick that brings the counter to zero sets the status bit and clears the enable bit, which reads back as zero. The counter then holds at zero.
- R7: Status bit i (bits [1:0] at 0x18) clears when a one is written to it. Writing zero leaves it unchanged. If a channel reaches zero in the same cycle as a clear write, the bit stays set.
- R8: Interrupt output irq_o[i] is high exactly when status bit i and channel i's interrupt enable are both set.
- R9: After reset every register reads zero, both counters are stopped and both interrupt outputs are low.
- R10: Clearing the enable bit freezes the counter and keeps the mode. A control write with enable set to a channel that is already enabled does not reload the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Write strobe, qualified by req_i |
| addr_i | input | 5 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 2 | Per-channel interrupt |

## Verification
The assertions assume that only a control write can change a channel's enable or mode. Every property that concerns one-shot stopping, periodic continuation, the frozen count or the single-step count excludes cycles that write that channel's control register. The bench changes the prescale value only in writes that also start a stopped channel, so no running prescaler is left above its new limit. It uses only the six defined word offsets, plus one unused offset for the reads-as-zero case.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 5;
  localparam int NUM_CH = 2;

  localparam logic [ADDR_W-1:0] OFS_CTL0  = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_CTL1  = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_INIT0 = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_INIT1 = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_CNT1  = 5'h14;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 5'h18;

  localparam int BIT_EN  = 30;
  localparam int BIT_IE  = 29;
  localparam int BIT_PER = 27;
endpackage

// File: rtl/dtmr_prescale.sv
module dtmr_prescale #(
  parameter int PRE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [PRE_W-1:0] limit_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] pcnt_q;
  logic             at_lim;

  assign at_lim = (pcnt_q == limit_i);
  assign tick_o = run_i && !restart_i && at_lim;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pcnt_q <= '0;
    else if (restart_i) pcnt_q <= '0;
    else if (run_i)     pcnt_q <= at_lim ? '0 : pcnt_q + 1'b1;
  end
endmodule

// File: rtl/dtmr_count.sv
module dtmr_count #(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             tick_i,
  input  logic             periodic_i,
  input  logic [CNT_W-1:0] init_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q, nxt;

  // zero: periodic reloads, one-shot stays
  always_comb begin
    if (cnt_q == '0) nxt = periodic_i ? init_i : '0;
    else             nxt = cnt_q - 1'b1;
  end

  assign hit_o = tick_i && (nxt == '0);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= init_i;
    else if (tick_i) cnt_q <= nxt;
  end
endmodule

// File: rtl/dtmr_channel.sv
module dtmr_channel
  import dtmr_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int PRE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_we_i,
  input  logic              init_we_i,
  input  logic              wr_en_i,
  input  logic              wr_ie_i,
  input  logic              wr_per_i,
  input  logic [PRE_W-1:0]  wr_pre_i,
  input  logic [CNT_W-1:0]  wr_init_i,
  output logic [DATA_W-1:0] ctl_o,
  output logic [CNT_W-1:0]  init_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              en_o,
  output logic              ie_o,
  output logic              per_o,
  output logic              hit_o
);
  logic             en_q, ie_q, per_q;
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] init_q;
  logic             arm, tick;

  assign arm = ctl_we_i && wr_en_i && !en_q;

  dtmr_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (en_q),
    .restart_i (arm),
    .limit_i   (pre_q),
    .tick_o    (tick)
  );

  dtmr_count #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (arm),
    .tick_i     (tick),
    .periodic_i (per_q),
    .init_i     (init_q),
    .cnt_o      (cnt_o),
    .hit_o      (hit_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      ie_q  <= 1'b0;
      per_q <= 1'b0;
      pre_q <= '0;
    end else if (ctl_we_i) begin
      en_q  <= wr_en_i;
      ie_q  <= wr_ie_i;
      per_q <= wr_per_i;
      pre_q <= wr_pre_i;
    end else if (hit_o && !per_q) begin
      en_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        init_q <= '0;
    else if (init_we_i) init_q <= wr_init_i;
  end

  always_comb begin
    ctl_o              = '0;
    ctl_o[BIT_EN]      = en_q;
    ctl_o[BIT_IE]      = ie_q;
    ctl_o[BIT_PER]     = per_q;
    ctl_o[PRE_W-1:0]   = pre_q;
  end

  assign init_o = init_q;
  assign en_o   = en_q;
  assign ie_o   = ie_q;
  assign per_o  = per_q;
endmodule

// File: rtl/dual_timer.sv
module dual_timer
  import dtmr_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int PRE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NUM_CH-1:0] irq_o
);
  logic                             wr;
  logic [NUM_CH-1:0]                en_w, ie_w, per_w, hit_w;
  logic [NUM_CH-1:0][CNT_W-1:0]     cnt_w, init_w;
  logic [NUM_CH-1:0][DATA_W-1:0]    ctl_w;
  logic [NUM_CH-1:0]                stat_q, clr;
  logic                             unused_bits;

  assign wr = req_i && we_i;
  assign unused_bits = ^{wdata_i, cnt_w[0]};

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_CTL  = (i == 0) ? OFS_CTL0  : OFS_CTL1;
    localparam logic [ADDR_W-1:0] A_INIT = (i == 0) ? OFS_INIT0 : OFS_INIT1;
    dtmr_channel #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ctl_we_i  (wr && addr_i == A_CTL),
      .init_we_i (wr && addr_i == A_INIT),
      .wr_en_i   (wdata_i[BIT_EN]),
      .wr_ie_i   (wdata_i[BIT_IE]),
      .wr_per_i  (wdata_i[BIT_PER]),
      .wr_pre_i  (wdata_i[PRE_W-1:0]),
      .wr_init_i (wdata_i[CNT_W-1:0]),
      .ctl_o     (ctl_w[i]),
      .init_o    (init_w[i]),
      .cnt_o     (cnt_w[i]),
      .en_o      (en_w[i]),
      .ie_o      (ie_w[i]),
      .per_o     (per_w[i]),
      .hit_o     (hit_w[i])
    );
  end

  assign clr = (wr && addr_i == OFS_STAT) ? wdata_i[NUM_CH-1:0] : '0;

  // a new hit outranks a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~clr) | hit_w;
  end

  assign irq_o = stat_q & ie_w;

  always_comb begin
    unique case (addr_i)
      OFS_CTL0:  rdata_o = ctl_w[0];
      OFS_CTL1:  rdata_o = ctl_w[1];
      OFS_INIT0: rdata_o = DATA_W'(init_w[0]);
      OFS_INIT1: rdata_o = DATA_W'(init_w[1]);
      OFS_CNT1:  rdata_o = DATA_W'(cnt_w[1]);
      OFS_STAT:  rdata_o = DATA_W'(stat_q);
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dual_timer_chk.sv
module dual_timer_chk
  import dtmr_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int PRE_W = 8
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         req_i,
  input logic                         we_i,
  input logic [ADDR_W-1:0]            addr_i,
  input logic [DATA_W-1:0]            wdata_i,
  input logic [NUM_CH-1:0]            irq_o,
  input logic [NUM_CH-1:0]            stat_q,
  input logic [NUM_CH-1:0]            en_w,
  input logic [NUM_CH-1:0]            per_w,
  input logic [NUM_CH-1:0]            hit_w,
  input logic [NUM_CH-1:0][CNT_W-1:0] cnt_w
);
  logic unused_chk;
  logic wstat;
  assign unused_chk = ^{wdata_i, PRE_W[0]};
  assign wstat = req_i && we_i && addr_i == OFS_STAT;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_a
    localparam logic [ADDR_W-1:0] A_CTL = (i == 0) ? OFS_CTL0 : OFS_CTL1;
    logic wctl;
    assign wctl = req_i && we_i && addr_i == A_CTL;

    assert_hit_sets_status_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_w[i] |=> stat_q[i]);

    assert_clear_drops_irq_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wstat && wdata_i[i] && !hit_w[i] |=> !irq_o[i]);

    assert_oneshot_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_w[i] && !per_w[i] && !wctl |=> !en_w[i] && cnt_w[i] == '0);

    assert_periodic_run_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_w[i] && per_w[i] && !wctl |=> en_w[i]);

    assert_paused_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_w[i] && !wctl |=> $stable(cnt_w[i]));

    assert_single_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_w[i] && !wctl && cnt_w[i] != '0 |=>
        (cnt_w[i] == $past(cnt_w[i]) || cnt_w[i] == $past(cnt_w[i]) - CNT_W'(1)));
  end
endmodule

bind dual_timer dual_timer_chk #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .irq_o   (irq_o),
  .stat_q  (stat_q),
  .en_w    (en_w),
  .per_w   (per_w),
  .hit_w   (hit_w),
  .cnt_w   (cnt_w)
);

// File: tb/dual_timer_tb.sv
module dual_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [4:0]  addr = 5'h1C;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  irq;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  bit          m_en[2], m_ie[2], m_per[2];
  int          m_pre[2], m_pc[2];
  logic [23:0] m_init[2], m_cnt[2];
  logic [1:0]  m_st;

  always #5 clk = ~clk;

  dual_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_en[c] = 0; m_ie[c] = 0; m_per[c] = 0;
        m_pre[c] = 0; m_pc[c] = 0; m_init[c] = '0; m_cnt[c] = '0;
      end
      m_st = '0;
    end else begin
      logic [1:0] hits;
      hits = '0;
      for (int c = 0; c < 2; c++) begin
        bit wc, wi, rise, tick;
        wc   = req && we && (addr == (c == 1 ? 5'd4 : 5'd0));
        wi   = req && we && (addr == (c == 1 ? 5'd12 : 5'd8));
        rise = wc && wdata[30] && !m_en[c];
        tick = m_en[c] && !rise && (m_pc[c] == m_pre[c]);
        if (rise) begin
          m_cnt[c] = m_init[c];
          m_pc[c]  = 0;
        end else begin
          if (m_en[c]) m_pc[c] = (m_pc[c] == m_pre[c]) ? 0 : (m_pc[c] + 1) % 256;
          if (tick) begin
            if (m_cnt[c] == 0) m_cnt[c] = m_per[c] ? m_init[c] : 24'd0;
            else               m_cnt[c] = m_cnt[c] - 1;
            if (m_cnt[c] == 0) hits[c] = 1'b1;
          end
        end
        if (wc) begin
          m_en[c] = wdata[30]; m_ie[c] = wdata[29];
          m_per[c] = wdata[27]; m_pre[c] = int'(wdata[7:0]);
        end else if (hits[c] && !m_per[c]) m_en[c] = 0;
        if (wi) m_init[c] = wdata[23:0];
      end
      if (req && we && addr == 5'd24) m_st = m_st & ~wdata[1:0];
      m_st = m_st | hits;
    end
  end

  function automatic logic [31:0] m_ctl(int c);
    return (32'(m_en[c]) << 30) | (32'(m_ie[c]) << 29) | (32'(m_per[c]) << 27) | 32'(m_pre[c]);
  endfunction

  function automatic logic [31:0] m_read(logic [4:0] a);
    case (a)
      5'd0:  return m_ctl(0);
      5'd4:  return m_ctl(1);
      5'd8:  return {8'h0, m_init[0]};
      5'd12: return {8'h0, m_init[1]};
      5'd20: return {8'h0, m_cnt[1]};
      5'd24: return {30'h0, m_st};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison with the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      string tg;
      chk("R8 irq vs model", 32'(irq), 32'(m_st & {m_ie[1], m_ie[0]}));
      case (addr)
        5'd0, 5'd4: tg = "R2 ctl vs model";
        5'd20:      tg = "R4 count vs model";
        5'd24:      tg = "R7 status vs model";
        default:    tg = "R1 read vs model";
      endcase
      chk(tg, rdata, m_read(addr));
    end
  end

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); #1;
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); #1;
    req = 0; we = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(posedge clk);
    @(negedge clk); #1;
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    #23 rst_n = 1'b1;
    @(negedge clk); #1;

    // R9 reset state
    foreach (v[k]) if (k < 7) begin
      rd(5'(k * 4), v); chk("R9 reset read", v, 32'h0);
    end
    chk("R9 reset irq", 32'(irq), 32'h0);

    // R1 map and readback
    wr(5'h08, 32'hAB123456); rd(5'h08, v); chk("R1 init0 readback", v, 32'h00123456);
    wr(5'h0C, 32'h00FFFFFF); rd(5'h0C, v); chk("R1 init1 readback", v, 32'h00FFFFFF);
    rd(5'h1C, v); chk("R1 unused offset", v, 32'h0);

    // R2 control fields
    wr(5'h00, 32'h280000FF); rd(5'h00, v); chk("R2 ctl fields", v, 32'h280000FF);
    wr(5'h00, 32'h97FFFFFF); rd(5'h00, v); chk("R2 undefined bits", v, 32'h000000FF);

    // R3 / R4 prescale 3 on channel 1
    wr(5'h0C, 32'd100);
    wr(5'h04, 32'h40000003);
    rd(5'h14, v); chk("R4 load on arm", v, 32'd100);
    wait_cyc(40);
    rd(5'h14, v); chk("R3 step per prescale", v, 32'd90);

    // R10 pause and re-enable
    wr(5'h04, 32'h08000003);
    rd(5'h14, v); wait_cyc(12); rd(5'h14, v2);
    chk("R10 frozen while paused", v2, v);
    rd(5'h04, v); chk("R10 mode kept", v, 32'h08000003);
    wr(5'h04, 32'h40000003);
    rd(5'h14, v); chk("R4 reload on rising enable", v, 32'd100);
    wait_cyc(9);
    wr(5'h04, 32'h40000003);
    rd(5'h14, v); chk("R10 no reload when already enabled", 32'(v < 32'd100), 32'd1);
    wr(5'h04, 32'h0);

    // R6 one-shot on channel 0
    wr(5'h08, 32'd5);
    wr(5'h00, 32'h60000000);
    wait_cyc(4);
    chk("R6 not yet expired", 32'(irq[0]), 32'd0);
    wait_cyc(1);
    chk("R6 expiry irq", 32'(irq[0]), 32'd1);
    rd(5'h00, v); chk("R6 enable cleared", v, 32'h20000000);
    wait_cyc(10);
    rd(5'h18, v); chk("R6 status held", v & 32'h1, 32'h1);

    // R7 write-one-to-clear
    wr(5'h18, 32'h0); rd(5'h18, v); chk("R7 zero write ignored", v & 32'h1, 32'h1);
    wr(5'h18, 32'h1); rd(5'h18, v); chk("R7 clear", v, 32'h0);
    chk("R7 irq after clear", 32'(irq), 32'h0);

    // R5 periodic on channel 0, period 4
    wr(5'h08, 32'd3);
    wr(5'h00, 32'h68000000);
    wait_cyc(3);
    chk("R5 first hit", 32'(irq[0]), 32'd1);
    wr(5'h18, 32'h1);
    chk("R5 cleared", 32'(irq[0]), 32'd0);
    wait_cyc(3);
    chk("R5 second hit", 32'(irq[0]), 32'd1);
    rd(5'h00, v); chk("R5 stays enabled", v, 32'h68000000);
    wr(5'h00, 32'h0);
    wr(5'h18, 32'h3);

    // R8 status without interrupt enable, R7 hit beats clear
    wr(5'h0C, 32'd0);
    wr(5'h04, 32'h48000000);
    wait_cyc(2);
    rd(5'h18, v); chk("R8 status bit1 set", v & 32'h2, 32'h2);
    chk("R8 irq masked", 32'(irq[1]), 32'd0);
    wr(5'h18, 32'h2);
    rd(5'h18, v); chk("R7 hit wins over clear", v & 32'h2, 32'h2);
    wr(5'h04, 32'h0);
    wr(5'h18, 32'h3);
    rd(5'h18, v); chk("R7 clear after stop", v, 32'h0);

    // mixed traffic checked against the model every cycle
    wr(5'h08, 32'd2); wr(5'h00, 32'h68000001);
    wr(5'h0C, 32'd4); wr(5'h04, 32'h68000000);
    for (int n = 0; n < 400; n++) begin
      int op;
      op = $urandom_range(0, 9);
      case (op)
        0: wr(5'h18, 32'($urandom_range(0, 3)));
        1: wr(5'h08, 32'($urandom_range(0, 6)));
        2: wr(5'h0C, 32'($urandom_range(0, 6)));
        3: wr(5'h00, ($urandom_range(0, 1) ? 32'h40000000 : 32'h0) | 32'h28000001);
        4: wr(5'h04, ($urandom_range(0, 1) ? 32'h40000000 : 32'h0) | 32'h20000000);
        default: begin
          addr = 5'($urandom_range(0, 7) * 4);
          wait_cyc($urandom_range(0, 3));
        end
      endcase
    end

    done = 1;
    summary();
    $finish;
  end
endmodule